// File: doc/BRIEF.md
# Codec Register Write Engine over I2C

This block is an I2C bus master that does one job: it writes a single register inside an audio codec. The codec's register space uses 7-bit register numbers holding 9-bit values. Because a byte-oriented bus cannot carry that split directly, the engine packs both into two payload bytes. These follow the codec's device address byte. The codec offers no read path, so the engine only writes.

The host prepares a transfer in two steps. First it loads a 32-bit command word. The register number sits in bits 31:25 and the value in bits 24:16; all other bits are don't-care. Then it writes the control port with three flags raised together: go, final-byte and address-phase. The go flag reads back as 1 while the transfer runs and drops to 0 when the STOP condition has been sent. If the codec leaves any byte unacknowledged, the engine ends the transfer early with a STOP and raises the abort flag. Retry policy stays with the host, which treats a clear abort flag after go falls as success.

Both host ports are plain register strobes. The engine has no data stream, so it needs no valid/ready handshake and applies no back-pressure. A control write that arrives while a transfer runs is dropped. A command write at that time only affects the next transfer.

Top module: `codec_i2c_wr`

## Requirements
- R1: After reset, flag_go and flag_abort are 0, and scl_o and sda_o are both 1 (bus released).
- R2: A transfer starts only on a control write with ctl_go, ctl_final and ctl_devph all 1 while flag_go is 0. A control write with any of the three flags at 0 is ignored: flag_go stays 0 and no START appears on the bus.
- R3: flag_go becomes 1 in the cycle after the accepting control write. It stays 1 until the STOP has completed, then returns to 0 with both lines released.
- R4: The bytes are sent MSB first, in this order: {DEV_ADDR, 0} (write bit is 0), then {cmd[31:25], cmd[24]}, then cmd[23:16].
- R5: During address and data bits, sda_o changes only while scl_o is low. The only SDA edges with SCL high are the START fall and the STOP rise, so there are exactly two per transfer.
- R6: Consecutive rising edges of scl_o within a transfer are 4*QTR_CYCLES system clock cycles apart.
- R7: A NACK (SDA high in the ninth clock) on any byte ends the transfer with a STOP. No further byte is sent, and flag_abort rises in the same cycle that flag_go falls.
- R8: When all three bytes are acknowledged, flag_abort is 0 after flag_go falls.
- R9: An accepted start clears flag_abort in the cycle after the control write.
- R10: While flag_go is 1, control writes are ignored and command writes do not alter the bytes of the transfer in progress.
- R11: Command bits 15:0 have no effect on the bytes sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_word | input | 32 | Command word: register in 31:25, value in 24:16 |
| ctl_we | input | 1 | Control write strobe |
| ctl_go | input | 1 | Control flag: go |
| ctl_final | input | 1 | Control flag: final byte |
| ctl_devph | input | 1 | Control flag: address phase |
| flag_go | output | 1 | Go flag readback, 1 while a transfer runs |
| flag_abort | output | 1 | Set when the last transfer saw a NACK |
| scl_o | output | 1 | SCL drive, 1 = released |
| sda_o | output | 1 | SDA drive, 1 = released |
| sda_i | input | 1 | SDA line as seen on the bus |

## Verification
The bench aims at the packing of the 7+9 split across the byte boundary. It uses all-ones and all-zeros commands with junk in the low half, because an off-by-one split would move value bit 8 into the wrong byte or let low bits leak into the frame. A bus model sends NACKs on each of the three bytes in turn. A design that kept sending after a NACK would show more bytes than expected, and one that set abort too early or too late would break the required alignment with the fall of go. Further tests check that a stale abort is cleared on restart and that host writes during a busy transfer are dropped. Without that protection the engine would show a second START or corrupted bytes. The bench also measures the SCL period and counts SDA edges while SCL is high, to catch data changing in the high phase.

// File: rtl/cdc_pkg.sv
package cdc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_BIT   = 2'd2,
    PH_STOP  = 2'd3
  } eng_ph_t;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned N_BYTES = 3;
  localparam int unsigned FRAME_W = BYTE_W * N_BYTES;
  localparam int unsigned REG_W   = 7;
  localparam int unsigned VAL_W   = 9;
endpackage

// File: rtl/cdc_qtick.sv
module cdc_qtick #(
  parameter int unsigned QTR_CYCLES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + CW'(1);
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/cdc_cmd_reg.sv
module cdc_cmd_reg
  import cdc_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h1A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [31:0]        word,
  output logic [FRAME_W-1:0] frame
);
  localparam int unsigned PAY_W = REG_W + VAL_W;

  logic [PAY_W-1:0] payload;

  always_ff @(posedge clk) begin
    if (!rst_n) payload <= '0;
    else if (we) payload <= word[31 -: PAY_W];
  end

  // device byte with write bit 0, then {reg, val[8]}, then val[7:0]
  assign frame = {DEV_ADDR, 1'b0, payload};
endmodule

// File: rtl/cdc_engine.sv
module cdc_engine
  import cdc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic               tick,
  input  logic [FRAME_W-1:0] frame,
  input  logic               sda_i,
  output logic               busy,
  output logic               abort,
  output logic               scl,
  output logic               sda,
  output logic               data_phase
);
  eng_ph_t            ph;
  logic [1:0]         q;
  logic [3:0]         bitn;
  logic [1:0]         byten;
  logic [FRAME_W-1:0] sh;
  logic               nack;

  localparam logic [3:0] ACK_BIT   = 4'(BYTE_W);
  localparam logic [1:0] LAST_BYTE = 2'(N_BYTES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      q     <= '0;
      bitn  <= '0;
      byten <= '0;
      sh    <= '0;
      nack  <= 1'b0;
      busy  <= 1'b0;
      abort <= 1'b0;
      scl   <= 1'b1;
      sda   <= 1'b1;
    end else if (ph == PH_IDLE) begin
      if (launch) begin
        ph    <= PH_START;
        q     <= '0;
        sh    <= frame;
        byten <= '0;
        nack  <= 1'b0;
        busy  <= 1'b1;
        abort <= 1'b0;
      end
    end else if (tick) begin
      q <= q + 2'd1;
      unique case (ph)
        PH_START: begin
          if (q == 2'd0) sda <= 1'b0;
          if (q == 2'd2) scl <= 1'b0;
          if (q == 2'd3) begin
            ph   <= PH_BIT;
            bitn <= '0;
          end
        end
        PH_BIT: begin
          unique case (q)
            2'd0: sda <= (bitn == ACK_BIT) ? 1'b1 : sh[FRAME_W-1];
            2'd1: scl <= 1'b1;
            2'd2: if (bitn == ACK_BIT) nack <= sda_i;
            default: begin
              scl <= 1'b0;
              if (bitn != ACK_BIT) begin
                sh   <= sh << 1;
                bitn <= bitn + 4'd1;
              end else if (nack || byten == LAST_BYTE) begin
                ph <= PH_STOP;
              end else begin
                byten <= byten + 2'd1;
                bitn  <= '0;
              end
            end
          endcase
        end
        PH_STOP: begin
          if (q == 2'd0) sda <= 1'b0;
          if (q == 2'd1) scl <= 1'b1;
          if (q == 2'd2) sda <= 1'b1;
          if (q == 2'd3) begin
            ph    <= PH_IDLE;
            busy  <= 1'b0;
            abort <= nack;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign data_phase = (ph == PH_BIT);
endmodule

// File: rtl/codec_i2c_wr.sv
module codec_i2c_wr
  import cdc_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR   = 7'h1A,
  parameter int unsigned QTR_CYCLES = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [31:0] cmd_word,
  input  logic        ctl_we,
  input  logic        ctl_go,
  input  logic        ctl_final,
  input  logic        ctl_devph,
  output logic        flag_go,
  output logic        flag_abort,
  output logic        scl_o,
  output logic        sda_o,
  input  logic        sda_i
);
  logic [FRAME_W-1:0] frame;
  logic               tick;
  logic               launch;
  logic               data_phase;

  assign launch = ctl_we && ctl_go && ctl_final && ctl_devph && !flag_go;

  cdc_cmd_reg #(.DEV_ADDR(DEV_ADDR)) u_cmd (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cmd_we),
    .word  (cmd_word),
    .frame (frame)
  );

  cdc_qtick #(.QTR_CYCLES(QTR_CYCLES)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (flag_go),
    .tick  (tick)
  );

  cdc_engine u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .tick       (tick),
    .frame      (frame),
    .sda_i      (sda_i),
    .busy       (flag_go),
    .abort      (flag_abort),
    .scl        (scl_o),
    .sda        (sda_o),
    .data_phase (data_phase)
  );
endmodule

// File: rtl/cdc_checker.sv
module cdc_checker (
  input logic clk,
  input logic rst_n,
  input logic ctl_we,
  input logic ctl_go,
  input logic ctl_final,
  input logic ctl_devph,
  input logic flag_go,
  input logic flag_abort,
  input logic scl_o,
  input logic sda_o,
  input logic data_phase
);
  logic accept;
  assign accept = ctl_we && ctl_go && ctl_final && ctl_devph && !flag_go;

  // R2: no transfer running means both lines released
  a_r2_idle_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_go |-> (scl_o && sda_o));

  // R3: go only rises after an accepting control write
  a_r3_go_rise_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_go) |-> $past(ctl_we && ctl_go && ctl_final && ctl_devph));

  // R5: SDA steady through the high phase of every address/data/ack bit
  a_r5_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (data_phase && scl_o && $past(scl_o)) |-> $stable(sda_o));

  // R7: abort appears only as the transfer ends
  a_r7_abort_with_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_abort) |-> $fell(flag_go));

  // R9: accepted start clears abort and raises go
  a_r9_start_clears_abort: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (flag_go && !flag_abort));
endmodule

bind codec_i2c_wr cdc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_we     (ctl_we),
  .ctl_go     (ctl_go),
  .ctl_final  (ctl_final),
  .ctl_devph  (ctl_devph),
  .flag_go    (flag_go),
  .flag_abort (flag_abort),
  .scl_o      (scl_o),
  .sda_o      (sda_o),
  .data_phase (data_phase)
);

// File: tb/test_codec_i2c_wr.sv
module test_codec_i2c_wr;
  localparam logic [6:0] DEV = 7'h1A;
  localparam int QTR = 5;

  // {reg[6:0], val[8:0], junk[15:0], nack_at[1:0]} ; nack_at 3 = all acked
  localparam logic [33:0] VEC [0:4] = '{
    {7'h7F, 9'h1FF, 16'hA5A5, 2'd3},
    {7'h00, 9'h000, 16'hFFFF, 2'd3},
    {7'h15, 9'h12C, 16'h1234, 2'd1},
    {7'h40, 9'h100, 16'h0F0F, 2'd0},
    {7'h2A, 9'h0AA, 16'h8001, 2'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0;
  logic [31:0] cmd_word = '0;
  logic ctl_we = 1'b0, ctl_go = 1'b0, ctl_final = 1'b0, ctl_devph = 1'b0;
  logic flag_go, flag_abort, scl_o, sda_o;
  logic ack_drv = 1'b0;
  logic sda_line;

  always #10 clk = ~clk;

  assign sda_line = sda_o & ~ack_drv;

  codec_i2c_wr #(.DEV_ADDR(DEV), .QTR_CYCLES(QTR)) i_codec_i2c_wr (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(cmd_word),
    .ctl_we(ctl_we), .ctl_go(ctl_go), .ctl_final(ctl_final), .ctl_devph(ctl_devph),
    .flag_go(flag_go), .flag_abort(flag_abort), .scl_o(scl_o), .sda_o(sda_o),
    .sda_i(sda_line)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // bus slave model
  bit act = 0;
  int bc = 0, bi = 0, starts = 0, nack_at = 3;
  logic [7:0] shr = '0;
  logic [7:0] rx [0:3];

  always @(negedge sda_line) if (scl_o) begin act = 1; bc = 0; bi = 0; starts++; end
  always @(posedge sda_line) if (scl_o) act = 0;
  always @(posedge scl_o) if (act) begin
    if (bc < 8) shr = {shr[6:0], sda_line};
    bc++;
  end
  always @(negedge scl_o) if (act) begin
    if (bc == 8) ack_drv = (bi != nack_at);
    else if (bc == 9) begin
      ack_drv = 0;
      if (bi < 4) rx[bi] = shr;
      bi++;
      bc = 0;
    end
  end

  // line monitor, sampled away from the active edge
  int cyc = 0, last_rise = -1, per_min = 0, per_max = 0, hi_chg = 0;
  logic p_scl = 1'b1, p_sda = 1'b1;
  always @(negedge clk) begin
    cyc++;
    if (scl_o && p_scl && sda_o != p_sda) hi_chg++;
    if (scl_o && !p_scl) begin
      if (last_rise >= 0) begin
        if (cyc - last_rise < per_min) per_min = cyc - last_rise;
        if (cyc - last_rise > per_max) per_max = cyc - last_rise;
      end
      last_rise = cyc;
    end
    p_scl = scl_o;
    p_sda = sda_o;
  end

  task automatic check(string req, string what, int actv, int expv);
    n_tests++;
    if (actv != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, actv, expv);
    end
  endtask

  task automatic clr_mon();
    starts = 0; bi = 0; hi_chg = 0; last_rise = -1; per_min = 1 << 20; per_max = 0;
    for (int i = 0; i < 4; i++) rx[i] = 8'h00;
  endtask

  task automatic load_cmd(logic [31:0] w);
    @(negedge clk); cmd_we = 1; cmd_word = w;
    @(negedge clk); cmd_we = 0;
  endtask

  task automatic ctl_write(logic g, logic f, logic d);
    ctl_we = 1; ctl_go = g; ctl_final = f; ctl_devph = d;
    @(negedge clk); ctl_we = 0; ctl_go = 0; ctl_final = 0; ctl_devph = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && flag_go; i++) @(negedge clk);
    check("R3", "go cleared at end", flag_go, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "go after reset", flag_go, 0);
    check("R1", "abort after reset", flag_abort, 0);
    check("R1", "lines after reset", {scl_o, sda_o}, 2'b11);
    rst_n = 1;
    @(negedge clk);

    // R2 partial flag sets are ignored
    clr_mon();
    load_cmd(32'hFFFF_0000);
    ctl_write(1, 1, 0);
    ctl_write(1, 0, 1);
    ctl_write(0, 1, 1);
    repeat (40) @(negedge clk);
    check("R2", "go after partial flags", flag_go, 0);
    check("R2", "starts after partial flags", starts, 0);
    check("R2", "lines after partial flags", {scl_o, sda_o}, 2'b11);

    // table walk: R4 R5 R6 R7 R8 R9 R11
    for (int v = 0; v < 5; v++) begin
      logic [31:0] w;
      int nk, exp_n;
      logic [7:0] eb [0:2];
      w = VEC[v][33:2];
      nk = int'(VEC[v][1:0]);
      exp_n = (nk == 3) ? 3 : nk + 1;
      eb[0] = {DEV, 1'b0};
      eb[1] = w[31:24];
      eb[2] = w[23:16];
      load_cmd(w);
      clr_mon();
      nack_at = nk;
      ctl_write(1, 1, 1);
      check("R3", "go rises next cycle", flag_go, 1);
      check("R9", "abort cleared on start", flag_abort, 0);
      wait_done();
      check("R3", "lines released at end", {scl_o, sda_o}, 2'b11);
      check("R4", "one START", starts, 1);
      check("R7", "bytes seen", bi, exp_n);
      for (int b = 0; b < 3; b++)
        if (b < exp_n) check("R4", $sformatf("byte %0d (R11 low bits ignored)", b), rx[b], eb[b]);
      check((nk == 3) ? "R8" : "R7", "abort flag", flag_abort, (nk == 3) ? 0 : 1);
      check("R5", "SDA edges with SCL high", hi_chg, 2);
      check("R6", "min SCL period", per_min, 4 * QTR);
      check("R6", "max SCL period", per_max, 4 * QTR);
      repeat (5) @(negedge clk);
    end

    // R10: writes during a busy transfer
    nack_at = 3;
    load_cmd({7'h33, 9'h0C3, 16'h0});
    clr_mon();
    ctl_write(1, 1, 1);
    repeat (150) @(negedge clk);
    cmd_we = 1; cmd_word = {7'h4C, 9'h13C, 16'h0};
    @(negedge clk); cmd_we = 0;
    ctl_write(1, 1, 1);
    wait_done();
    repeat (300) @(negedge clk);
    check("R10", "single START", starts, 1);
    check("R10", "no relaunch", flag_go, 0);
    check("R10", "byte 1 unchanged", rx[1], {7'h33, 1'b0});
    check("R10", "byte 2 unchanged", rx[2], 8'hC3);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule